// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block tells a DRAM controller when refresh work is due. Leaving reset, it holds off all requests for a fixed start-up pause. It then demands a fixed burst of refresh cycles. Only when every one of those cycles has been acknowledged does it declare the memory usable. From then on it adds one owed refresh per interval, so that the full row space is covered inside the retention period. The defaults assume a 100 MHz clock, 4096 refreshes per 64 ms, and a 200 us pause followed by eight refreshes.

The controller sees a request while refreshes are owed. It answers each refresh it performs with a one-cycle acknowledge. The refreshes rely on the memory's own internal row counter (CAS-before-RAS), so the block supplies no address. The number of owed refreshes is visible on an output. An urgent flag tells the controller to stop extending page-mode accesses once the backlog has grown too large.

Top module: `dram_refresh_pacer`

## Requirements
- R1: While the first PAUSE_CYC clock edges with reset released are counted, `rfsh_req` and `init_done` stay low. `rfsh_req` is high in the cycle after the PAUSE_CYC-th edge.
- R2: During the start-up burst, `rfsh_req` stays high. `rfsh_owed` shows the number of start-up refreshes still missing: it starts at BURST_LEN and falls by one on every acknowledge.
- R3: `init_done` rises in the cycle after the BURST_LEN-th accepted acknowledge and not earlier. It then stays high until reset.
- R4: After `init_done` rises, one refresh is added to `rfsh_owed` every INTERVAL_CYC cycles. The first is added on the INTERVAL_CYC-th edge after `init_done` rises, so that N intervals add exactly N refreshes.
- R5: Once initialised, `rfsh_req` is high exactly when `rfsh_owed` is nonzero.
- R6: An acknowledge taken while `rfsh_req` is high lowers `rfsh_owed` by one. An acknowledge that coincides with an interval tick leaves `rfsh_owed` unchanged.
- R7: An acknowledge while `rfsh_req` is low has no effect. It neither shortens the pause nor lowers `rfsh_owed`, even when it coincides with an interval tick.
- R8: `rfsh_urgent` is high exactly when `init_done` is high and `rfsh_owed` is at least URGENT_LVL.
- R9: `rfsh_owed` saturates at 2^CNT_W-1. Further ticks without acknowledges keep it there.
- R10: A low `rst_n` at a clock edge (synchronous, active low) returns the block to the start of the pause. In that state `rfsh_req`, `init_done`, `rfsh_urgent` and `rfsh_owed` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rfsh_ack | input | 1 | One cycle per refresh performed by the controller |
| rfsh_req | output | 1 | Refresh work is owed |
| init_done | output | 1 | Start-up pause and burst complete; memory usable |
| rfsh_urgent | output | 1 | Backlog at or above URGENT_LVL |
| rfsh_owed | output | CNT_W | Refreshes owed and not yet acknowledged |

## Verification
Acknowledges are applied in several patterns:
- Held high through the whole pause: this separates a pause that honours only its own timer from one that an early acknowledge can cut short.
- Single pulses with gaps during the burst: these check that the count steps down one at a time and that ready is declared on the last acknowledge.
- Withheld for many intervals: this measures pacing across ten intervals, the urgent threshold and saturation.
- Held high continuously: this drains the backlog and confirms that acknowledges with no request pending, even at a tick, change nothing.

A tick that coincides with an acknowledge is checked on its own, which catches an update that loses one of the two events.

// File: rtl/dram_rfsh_pkg.sv
// Package: shared phase encoding for the refresh scheduler.
// Assumes nothing beyond being compiled before its users.
package dram_rfsh_pkg;

    // Scheduler phase: start-up pause, start-up burst, normal running
    typedef enum logic [1:0] {
        PH_PAUSE = 2'd0,
        PH_BURST = 2'd1,
        PH_RUN   = 2'd2
    } rfsh_phase_e;

endpackage

// File: rtl/rfsh_tick.sv
// Module: rfsh_tick
// Periodic tick generator. While en is high it counts clock edges. It
// raises tick for one cycle in every LIMIT cycles, the first time after
// LIMIT-1 enabled edges. While en is low the count is held at zero.
// Assumes LIMIT >= 2.
module rfsh_tick #(
    parameter int LIMIT = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    assign tick = en && (cnt == LAST);

    // Count enabled cycles and wrap at the end of each period
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rfsh_backlog.sv
// Module: rfsh_backlog
// Owed-refresh counter. It can be loaded with a start value, incremented
// by a tick and decremented by an accepted acknowledge. Load has
// priority. An increment and a decrement together cancel. The count
// saturates at all-ones and never goes below zero.
// Assumes load_val fits in CNT_W bits.
module rfsh_backlog #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] count
);
    logic dec_ok;
    logic at_max;

    assign dec_ok = dec && (count != '0);
    assign at_max = (count == '1);

    // Update the owed count from load, tick and acknowledge events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (inc && !dec_ok) begin
            if (!at_max) begin
                count <= count + 1'b1;
            end
        end else if (dec_ok && !inc) begin
            count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/dram_refresh_pacer.sv
// Module: dram_refresh_pacer (top)
// Power-up and periodic refresh scheduler for a DRAM controller.
// - Waits PAUSE_CYC cycles after reset.
// - Then demands BURST_LEN refreshes.
// - Then declares the memory ready and adds one owed refresh every
//   INTERVAL_CYC cycles.
// The controller acknowledges each refresh with a one-cycle rfsh_ack.
// Acknowledges are taken only while rfsh_req is high.
// Assumes BURST_LEN >= 1, BURST_LEN and URGENT_LVL fit in CNT_W bits.
module dram_refresh_pacer
    import dram_rfsh_pkg::*;
#(
    parameter int PAUSE_CYC    = 20000,
    parameter int INTERVAL_CYC = 1560,
    parameter int BURST_LEN    = 8,
    parameter int URGENT_LVL   = 8,
    parameter int CNT_W        = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rfsh_ack,
    output logic             rfsh_req,
    output logic             init_done,
    output logic             rfsh_urgent,
    output logic [CNT_W-1:0] rfsh_owed
);
    localparam logic [CNT_W-1:0] BURST_V  = CNT_W'(BURST_LEN);
    localparam logic [CNT_W-1:0] URGENT_V = CNT_W'(URGENT_LVL);

    rfsh_phase_e phase;
    logic        pause_tick;
    logic        run_tick;
    logic        ack_take;
    logic        burst_last;

    assign ack_take   = rfsh_ack && rfsh_req;
    assign burst_last = (phase == PH_BURST) && ack_take
                        && (rfsh_owed == CNT_W'(1));

    // Start-up pause timer, running only in the pause phase
    rfsh_tick #(.LIMIT(PAUSE_CYC)) u_pause_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (phase == PH_PAUSE),
        .tick  (pause_tick)
    );

    // Refresh interval timer, running only once initialised
    rfsh_tick #(.LIMIT(INTERVAL_CYC)) u_intv_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (phase == PH_RUN),
        .tick  (run_tick)
    );

    // One counter holds the start-up burst and later the periodic backlog
    rfsh_backlog #(.CNT_W(CNT_W)) u_owed (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (pause_tick),
        .load_val (BURST_V),
        .inc      (run_tick),
        .dec      (ack_take),
        .count    (rfsh_owed)
    );

    // Phase sequencing: pause, then burst, then running until reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_PAUSE;
        end else begin
            case (phase)
                PH_PAUSE: if (pause_tick) phase <= PH_BURST;
                PH_BURST: if (burst_last) phase <= PH_RUN;
                default:  phase <= PH_RUN;
            endcase
        end
    end

    assign init_done   = (phase == PH_RUN);
    assign rfsh_req    = (phase != PH_PAUSE) && (rfsh_owed != '0);
    assign rfsh_urgent = init_done && (rfsh_owed >= URGENT_V);
endmodule

// File: rtl/rfsh_pacer_chk.sv
// Module: rfsh_pacer_chk
// Property checker for dram_refresh_pacer, attached by bind below.
// Observes the ports only, plus its own count of cycles since reset.
module rfsh_pacer_chk #(
    parameter int PAUSE_CYC  = 20000,
    parameter int URGENT_LVL = 8,
    parameter int CNT_W      = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rfsh_ack,
    input logic             rfsh_req,
    input logic             init_done,
    input logic             rfsh_urgent,
    input logic [CNT_W-1:0] rfsh_owed
);
    localparam int CYC_W = $clog2(PAUSE_CYC + 1);
    localparam logic [CYC_W-1:0] PAUSE_V = CYC_W'(PAUSE_CYC);

    logic [CYC_W-1:0] since_rst;

    // Saturating count of edges since reset release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != PAUSE_V) begin
            since_rst <= since_rst + 1'b1;
        end
    end

    // R1
    pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rfsh_req || init_done) |-> (since_rst == PAUSE_V));

    // R2
    burst_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_done && rfsh_owed != '0) |-> rfsh_req);

    // R3
    init_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    // R3
    init_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> ($past(rfsh_ack && rfsh_req) && rfsh_owed == '0));

    // R5
    req_owed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (rfsh_req == (rfsh_owed != '0)));

    // R6
    owed_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && $past(init_done)) |->
            ((rfsh_owed == $past(rfsh_owed)) ||
             (rfsh_owed == CNT_W'($past(rfsh_owed) + 1'b1)) ||
             (rfsh_owed == CNT_W'($past(rfsh_owed) - 1'b1))));

    // R7
    idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && !rfsh_req) |=> (rfsh_owed <= CNT_W'(1)));

    // R8
    urgent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_urgent |-> (init_done && rfsh_req && rfsh_owed >= CNT_W'(URGENT_LVL)));
endmodule

bind dram_refresh_pacer rfsh_pacer_chk #(
    .PAUSE_CYC  (PAUSE_CYC),
    .URGENT_LVL (URGENT_LVL),
    .CNT_W      (CNT_W)
) u_pacer_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rfsh_ack    (rfsh_ack),
    .rfsh_req    (rfsh_req),
    .init_done   (init_done),
    .rfsh_urgent (rfsh_urgent),
    .rfsh_owed   (rfsh_owed)
);

// File: tb/test_dram_refresh_pacer.sv
`timescale 1ns/1ps
// Directed bench for dram_refresh_pacer; one task per scenario.
module test_dram_refresh_pacer;
    localparam int PAUSE = 100;
    localparam int INTV  = 20;
    localparam int BURST = 8;
    localparam int URG   = 8;
    localparam int CW    = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rfsh_ack = 1'b0;
    logic          rfsh_req;
    logic          init_done;
    logic          rfsh_urgent;
    logic [CW-1:0] rfsh_owed;

    int n_chk = 0;
    int n_fail = 0;
    int run_edges = 0;
    bit track_init = 1'b0;
    bit init_lost = 1'b0;

    dram_refresh_pacer #(
        .PAUSE_CYC(PAUSE), .INTERVAL_CYC(INTV), .BURST_LEN(BURST),
        .URGENT_LVL(URG), .CNT_W(CW)
    ) i_dram_refresh_pacer (
        .clk(clk), .rst_n(rst_n), .rfsh_ack(rfsh_ack), .rfsh_req(rfsh_req),
        .init_done(init_done), .rfsh_urgent(rfsh_urgent), .rfsh_owed(rfsh_owed)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Advance n edges, ending at a falling edge; watch init_done stays high
    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            run_edges++;
            if (track_init && !init_done) init_lost = 1'b1;
        end
    endtask

    task automatic wait_until(input int k);
        while (run_edges < k) step(1);
    endtask

    task automatic do_reset();
        track_init = 1'b0;
        rst_n = 1'b0;
        rfsh_ack = 1'b0;
        step(3);
        rst_n = 1'b1;
        chk("R10 req after reset", rfsh_req, 0);
        chk("R10 init_done after reset", init_done, 0);
        chk("R10 urgent after reset", rfsh_urgent, 0);
        chk("R10 owed after reset", rfsh_owed, 0);
    endtask

    task automatic t_pause();
        rfsh_ack = 1'b1;
        step(PAUSE - 1);
        chk("R1 req low at end of pause", rfsh_req, 0);
        chk("R1 init_done low in pause", init_done, 0);
        chk("R7 ack in pause leaves owed", rfsh_owed, 0);
        rfsh_ack = 1'b0;
        step(1);
        chk("R1 req high after pause", rfsh_req, 1);
        chk("R2 owed loaded with burst", rfsh_owed, BURST);
    endtask

    task automatic t_burst();
        for (int i = 0; i < BURST; i++) begin
            chk("R2 owed counts burst down", rfsh_owed, BURST - i);
            chk("R2 req held in burst", rfsh_req, 1);
            chk("R3 init_done not early", init_done, 0);
            rfsh_ack = 1'b1;
            step(1);
            rfsh_ack = 1'b0;
            if (i < BURST - 1) step(1);
        end
        chk("R3 init_done after last ack", init_done, 1);
        chk("R5 req low with nothing owed", rfsh_req, 0);
        run_edges = 0;
        track_init = 1'b1;
    endtask

    task automatic t_first_tick();
        step(INTV - 1);
        chk("R4 no tick before interval", rfsh_owed, 0);
        step(1);
        chk("R4 first tick after interval", rfsh_owed, 1);
        chk("R5 req with owed refresh", rfsh_req, 1);
        rfsh_ack = 1'b1;
        step(1);
        rfsh_ack = 1'b0;
        chk("R6 ack lowers owed", rfsh_owed, 0);
        chk("R5 req drops when served", rfsh_req, 0);
    endtask

    task automatic t_tick_ack();
        wait_until(2 * INTV);
        chk("R4 second tick", rfsh_owed, 1);
        wait_until(3 * INTV - 1);
        rfsh_ack = 1'b1;
        step(1);
        chk("R6 tick and ack cancel", rfsh_owed, 1);
        step(1);
        rfsh_ack = 1'b0;
        chk("R6 ack after cancel", rfsh_owed, 0);
    endtask

    task automatic t_pacing();
        wait_until(11 * INTV - 1);
        chk("R8 owed below threshold", rfsh_owed, 7);
        chk("R8 urgent low below threshold", rfsh_urgent, 0);
        step(1);
        chk("R8 urgent at threshold", rfsh_urgent, 1);
        wait_until(13 * INTV);
        chk("R4 ten intervals give ten refreshes", rfsh_owed, 10);
    endtask

    task automatic t_saturate();
        wait_until(18 * INTV);
        chk("R9 owed reaches max", rfsh_owed, 15);
        wait_until(19 * INTV);
        chk("R9 owed holds at max", rfsh_owed, 15);
        chk("R8 urgent at max", rfsh_urgent, 1);
    endtask

    task automatic t_drain_idle_ack();
        rfsh_ack = 1'b1;
        step(15);
        chk("R6 back-to-back acks drain", rfsh_owed, 0);
        chk("R8 urgent clears when drained", rfsh_urgent, 0);
        wait_until(20 * INTV - 1);
        chk("R7 idle ack leaves owed at zero", rfsh_owed, 0);
        step(1);
        chk("R7 idle ack at tick ignored", rfsh_owed, 1);
        rfsh_ack = 1'b0;
        chk("R3 init_done never fell", init_lost, 0);
    endtask

    task automatic t_reset_mid();
        do_reset();
        step(5);
        chk("R10 pause restarts after reset", rfsh_req, 0);
    endtask

    initial begin
        #(20000 * 4);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        t_pause();
        t_burst();
        t_first_tick();
        t_tick_ack();
        t_pacing();
        t_saturate();
        t_drain_idle_ack();
        t_reset_mid();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule